// File: doc/BRIEF.md
# Serial/Parallel Attenuator Control Latch

This block is the digital front end of a 6-bit step attenuator whose least significant bit is worth 0.5 dB. It builds a control word in an input register and copies that word onto an output register, which sets the attenuation state. The word comes from one of two sources, chosen by a mode pin. In serial mode, a three-wire port shifts the word in one bit at a time, most significant bit first. In parallel mode, six direct pins supply the whole word.

A single level-sensitive latch enable copies the input register to the output register. The output never changes while latch enable is low. While latch enable is high, rising edges on the serial clock are ignored, so the word being applied cannot move. All control pins are asynchronous to the system clock. Each one passes through a two-flop synchronizer. Serial clock edges are found by comparing consecutive synchronized samples.

Top module: `atten_ctrl_latch`

## Requirements
- R1: After reset, the input register and `atten_state_o` are both zero, which is minimum attenuation.
- R2: In serial mode (`ser_mode_i` = 1), each rising edge of `ser_clk_i` shifts `ser_data_i` into bit 0 of the input register while the other bits move up one place. The first bit shifted in therefore ends in bit 5 of `atten_state_o` after six edges.
- R3: When more than six serial clock edges arrive before a latch, only the last six bits shifted in are kept. Older bits leave through the top.
- R4: While `latch_en_i` is high, the input register is copied to `atten_state_o`. The output shows the new word no later than the fourth system clock edge after `latch_en_i` rises.
- R5: While `latch_en_i` is high, rising edges of `ser_clk_i` do not change the input register.
- R6: In parallel mode (`ser_mode_i` = 0), the input register follows `par_word_i`, with bit i of the pins as bit i of the word. `ser_data_i` and `ser_clk_i` have no effect on it.
- R7: In either mode, `atten_state_o` stays constant while `latch_en_i` is low.
- R8: A change of `ser_mode_i` affects input-register loading at once. It changes `atten_state_o` only at the next latch. In serial mode, `par_word_i` is ignored.
- R9: Every control pin is resynchronized through two flops before use. A serial edge therefore needs its data held steady for at least three system clock cycles beforehand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_mode_i | input | 1 | Source select: 1 for serial, 0 for parallel |
| ser_data_i | input | 1 | Serial data bit |
| ser_clk_i | input | 1 | Serial shift clock, sampled by `clk` |
| latch_en_i | input | 1 | Level-sensitive load of the output register |
| par_word_i | input | WORD_W | Parallel control word |
| atten_state_o | output | WORD_W | Applied attenuation state |

## Verification
The hardest case to reach from the ports is a serial clock edge that arrives while latch enable is high. The input register is not visible, so a masked edge only shows up through a later latch. The stimulus first applies a known word. It then pulses the serial clock several times with data opposite to that word, all inside a single high phase of latch enable. After that it lowers latch enable and raises it again with no edges in between, and expects the first word again. Random rounds repeat this pattern and mix it with overlong shift sequences and mode switches that are not followed by a latch.

// File: rtl/atten_ctrl_pkg.sv
package atten_ctrl_pkg;
  localparam int unsigned ATTN_WORD_W  = 6;
  localparam int unsigned SYNC_DEPTH   = 2;

  typedef enum logic {
    SRC_PARALLEL = 1'b0,
    SRC_SERIAL   = 1'b1
  } src_sel_e;
endpackage

// File: rtl/atten_sync_bank.sv
module atten_sync_bank #(
  parameter int unsigned N      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [N-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_o = stage_q[LAST];
endmodule

// File: rtl/atten_input_reg.sv
module atten_input_reg
  import atten_ctrl_pkg::*;
#(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  src_sel_e     src_i,
  input  logic         le_i,
  input  logic         sclk_i,
  input  logic         sdat_i,
  input  logic [W-1:0] par_i,
  output logic [W-1:0] word_o,
  output logic         sclk_rise_o
);
  logic         sclk_prev_q;
  logic [W-1:0] word_q;

  function automatic logic [W-1:0] shift_msb_first(input logic [W-1:0] cur,
                                                   input logic         din);
    return {cur[W-2:0], din};
  endfunction

  function automatic logic [W-1:0] next_word(input src_sel_e     src,
                                             input logic         le,
                                             input logic         rise,
                                             input logic         din,
                                             input logic [W-1:0] cur,
                                             input logic [W-1:0] par);
    if (src == SRC_PARALLEL)  return par;
    if (rise && !le)          return shift_msb_first(cur, din);
    return cur;
  endfunction

  assign sclk_rise_o = sclk_i & ~sclk_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b0;
      word_q      <= '0;
    end else begin
      sclk_prev_q <= sclk_i;
      word_q      <= next_word(src_i, le_i, sclk_rise_o, sdat_i, word_q, par_i);
    end
  end

  assign word_o = word_q;
endmodule

// File: rtl/atten_out_latch.sv
module atten_out_latch #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         le_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state_q <= '0;
    else if (le_i) state_q <= word_i;
  end

  assign state_o = state_q;
endmodule

// File: rtl/atten_ctrl_latch.sv
module atten_ctrl_latch
  import atten_ctrl_pkg::*;
#(
  parameter int unsigned WORD_W      = ATTN_WORD_W,
  parameter int unsigned SYNC_STAGES = SYNC_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_mode_i,
  input  logic              ser_data_i,
  input  logic              ser_clk_i,
  input  logic              latch_en_i,
  input  logic [WORD_W-1:0] par_word_i,
  output logic [WORD_W-1:0] atten_state_o
);
  localparam int unsigned CTRL_W = 4;
  localparam int unsigned SYNC_W = WORD_W + CTRL_W;

  logic [SYNC_W-1:0] raw_vec;
  logic [SYNC_W-1:0] sync_vec;

  logic              mode_sync;
  logic              sdat_sync;
  logic              sclk_sync;
  logic              le_sync;
  logic [WORD_W-1:0] par_sync;
  logic              sclk_rise;
  logic [WORD_W-1:0] in_word;
  src_sel_e          src_sel;

  assign raw_vec = {par_word_i, latch_en_i, ser_clk_i, ser_data_i, ser_mode_i};

  atten_sync_bank #(
    .N      (SYNC_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (raw_vec),
    .sync_o  (sync_vec)
  );

  assign mode_sync = sync_vec[0];
  assign sdat_sync = sync_vec[1];
  assign sclk_sync = sync_vec[2];
  assign le_sync   = sync_vec[3];
  assign par_sync  = sync_vec[SYNC_W-1:CTRL_W];
  assign src_sel   = src_sel_e'(mode_sync);

  atten_input_reg #(
    .W (WORD_W)
  ) u_inreg (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_i       (src_sel),
    .le_i        (le_sync),
    .sclk_i      (sclk_sync),
    .sdat_i      (sdat_sync),
    .par_i       (par_sync),
    .word_o      (in_word),
    .sclk_rise_o (sclk_rise)
  );

  atten_out_latch #(
    .W (WORD_W)
  ) u_outlat (
    .clk     (clk),
    .rst_n   (rst_n),
    .le_i    (le_sync),
    .word_i  (in_word),
    .state_o (atten_state_o)
  );
endmodule

// File: rtl/atten_ctrl_latch_chk.sv
module atten_ctrl_latch_chk #(
  parameter int unsigned W = 6
) (
  input logic         clk,
  input logic         rst_n,
  input logic         mode_s,
  input logic         sdat_s,
  input logic         le_s,
  input logic         rise_s,
  input logic [W-1:0] par_s,
  input logic [W-1:0] in_w,
  input logic [W-1:0] out_w
);
  AST_HOLD_LE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !le_s |=> $stable(out_w)); // R7

  AST_LOAD_LE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    le_s |=> (out_w == $past(in_w))); // R4

  AST_MASK_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_s && le_s) |=> $stable(in_w)); // R5

  AST_PAR_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_s |=> (in_w == $past(par_s))); // R6

  AST_SHIFT_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_s && !le_s && rise_s) |=>
      (in_w == {$past(in_w[W-2:0]), $past(sdat_s)})); // R2

  AST_SERIAL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_s && !rise_s) |=> $stable(in_w)); // R8
endmodule

bind atten_ctrl_latch atten_ctrl_latch_chk #(.W(WORD_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .mode_s (mode_sync),
  .sdat_s (sdat_sync),
  .le_s   (le_sync),
  .rise_s (sclk_rise),
  .par_s  (par_sync),
  .in_w   (in_word),
  .out_w  (atten_state_o)
);

// File: tb/atten_ctrl_latch_tb.sv
module atten_ctrl_latch_tb;
  localparam int W = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ser_mode = 1'b1;
  logic         ser_data = 1'b0;
  logic         ser_clk = 1'b0;
  logic         latch_en = 1'b0;
  logic [W-1:0] par_word = '0;
  logic [W-1:0] atten_state;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [W-1:0] in_model  = '0;
  logic [W-1:0] out_model = '0;

  always #2 clk = ~clk;

  atten_ctrl_latch u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .ser_mode_i    (ser_mode),
    .ser_data_i    (ser_data),
    .ser_clk_i     (ser_clk),
    .latch_en_i    (latch_en),
    .par_word_i    (par_word),
    .atten_state_o (atten_state)
  );

  function automatic logic [W-1:0] model_shift(logic [W-1:0] cur, logic b);
    logic [W:0] wide;
    wide = ({1'b0, cur} << 1) | {{W{1'b0}}, b};
    return wide[W-1:0];
  endfunction

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic set_mode(logic m);
    ser_mode = m;
    wait_cyc(4);
  endtask

  task automatic shift_bit(logic b);
    ser_data = b;
    wait_cyc(3);
    ser_clk = 1'b1;
    wait_cyc(4);
    ser_clk = 1'b0;
    wait_cyc(4);
  endtask

  task automatic shift_word(logic [W-1:0] w);
    for (int k = W - 1; k >= 0; k--) shift_bit(w[k]);
  endtask

  task automatic do_latch();
    latch_en = 1'b1;
    wait_cyc(6);
    latch_en = 1'b0;
    wait_cyc(5);
  endtask

  task automatic latch_with_junk(int pulses);
    latch_en = 1'b1;
    wait_cyc(4);
    for (int p = 0; p < pulses; p++) begin
      ser_data = ~ser_data;
      wait_cyc(3);
      ser_clk = 1'b1;
      wait_cyc(4);
      ser_clk = 1'b0;
      wait_cyc(3);
    end
    latch_en = 1'b0;
    wait_cyc(5);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h0A77_E2B5));
    wait_cyc(3);
    // R1: reset state
    check("R1 reset", atten_state, 6'b000000);
    rst_n = 1'b1;
    wait_cyc(4);
    do_latch();
    check("R1 input register zero", atten_state, 6'b000000);

    // R2, R9: MSB first with synchronized pins
    shift_word(6'b100110);
    check("R7 no latch yet", atten_state, 6'b000000);
    latch_en = 1'b1;
    wait_cyc(4);
    check("R4 latency", atten_state, 6'b100110);
    wait_cyc(2);
    latch_en = 1'b0;
    wait_cyc(5);
    check("R2 msb first", atten_state, 6'b100110);

    // R5: clock masked while latch high
    ser_data = 1'b1;
    latch_with_junk(3);
    do_latch();
    check("R5 masked edges", atten_state, 6'b100110);

    // R3: overlong sequence keeps last six
    shift_bit(1'b1); shift_bit(1'b1); shift_bit(1'b0);
    shift_word(6'b010011);
    do_latch();
    check("R3 last six kept", atten_state, 6'b010011);

    // R6: parallel mode, serial pins ignored
    set_mode(1'b0);
    par_word = 6'b110001;
    wait_cyc(4);
    shift_bit(1'b0); shift_bit(1'b1);
    check("R7 parallel no latch", atten_state, 6'b010011);
    do_latch();
    check("R6 parallel word", atten_state, 6'b110001);

    // R8: mode switch, parallel pins ignored in serial
    set_mode(1'b1);
    par_word = 6'b001110;
    wait_cyc(4);
    do_latch();
    check("R8 par ignored serial", atten_state, 6'b110001);
    set_mode(1'b0);
    wait_cyc(4);
    check("R8 mode change no output", atten_state, 6'b110001);
    par_word = 6'b111111;
    wait_cyc(6);
    check("R7 hold le low", atten_state, 6'b110001);
    do_latch();
    check("R8 next latch", atten_state, 6'b111111);

    // random rounds
    in_model  = 6'b111111;
    out_model = 6'b111111;
    for (int i = 0; i < 40; i++) begin
      logic m;
      m = 1'($urandom % 2);
      if (m != ser_mode) set_mode(m);
      if (m) begin
        int n;
        n = W + int'($urandom % 4);
        for (int k = 0; k < n; k++) begin
          logic b;
          b = 1'($urandom % 2);
          shift_bit(b);
          in_model = model_shift(in_model, b);
        end
        if ($urandom % 3 == 0) begin
          latch_with_junk(2);
          out_model = in_model;
        end else if ($urandom % 4 != 0) begin
          do_latch();
          out_model = in_model;
        end
      end else begin
        par_word = W'($urandom);
        wait_cyc(4);
        in_model = par_word;
        if ($urandom % 4 != 0) begin
          do_latch();
          out_model = in_model;
        end
      end
      check("R4 random round", atten_state, out_model);
    end
    finish_run();
  end
endmodule